// File: doc/BRIEF.md
# Pulse-Swallow Dual-Modulus Feedback Divider

This block is the feedback divider of a frequency synthesizer loop. It sits after an external dual-modulus prescaler. Each output pulse of the prescaler reaches the block as a one-clock enable (`preEn`) in the system clock domain. The block steers the prescaler's modulus line: high asks for P+1, low asks for P. Over one division cycle it counts N prescaler pulses. During the first A of them it keeps the modulus line high. The oscillator therefore runs through (P+1)·A + P·(N−A) = P·N + A cycles per output pulse. With a reference divided by R, the loop settles at fout = (P·N + A)·fref / R. Typical modulus pairs are 16/17 or 32/33 on a transmit loop, and 32/33 or 64/65 on a receive loop.

Software writes a new count pair through `cfgN`/`cfgA` with a one-clock `cfgLoad` strobe. The pair goes into a holding latch only if it is legal: N of at least 3, and A strictly below N. An illegal pair raises `cfgErr` and leaves the latch untouched. The counters take the latched pair only when a division cycle ends, so a write never disturbs a cycle that is in progress.

Top module: `pulseSwallowDiv`

## Requirements
- R1: After reset, modCtl, divPulse and cfgErr are 0, and the divider runs with N=16 and A=0 until a legal pair has been loaded and a cycle boundary has passed.
- R2: Each division cycle takes exactly N preEn pulses. divPulse is high for exactly one clock, in the clock that follows the Nth preEn.
- R3: Within a cycle, modCtl is 1 (select P+1) while the first A preEn pulses are taken and 0 for the remaining N−A, giving P·N+A prescaler input cycles per divPulse.
- R4: When A=0, modCtl stays 0 for the whole cycle.
- R5: A legal pair loaded mid-cycle or at a boundary does not alter the cycle in progress. It first governs the cycle that starts at the next divPulse.
- R6: A load with N<3 or A≥N sets cfgErr to 1 and keeps the previously latched pair. A legal load clears cfgErr. cfgErr changes only in the clock after a load.
- R7: A clock without preEn changes nothing: modCtl holds its value and no divPulse follows.
- R8: The extreme legal pairs N=3 with A=2, and N=2047 with A=127, are accepted without error and divide as in R2 and R3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| preEn | input | 1 | One-clock pulse per prescaler output edge |
| cfgLoad | input | 1 | Strobe that offers cfgN/cfgA to the holding latch |
| cfgN | input | 11 | Main count N offered on a load |
| cfgA | input | 7 | Swallow count A offered on a load |
| modCtl | output | 1 | Prescaler modulus select, 1 = P+1, 0 = P |
| divPulse | output | 1 | One-clock pulse per complete division cycle |
| cfgErr | output | 1 | Last load offered an illegal pair |

## Verification
The scoreboard counts the enables and the modulus-high enables between consecutive output pulses. An off-by-one in the main counter shows up as N±1 enables per cycle. A swallow counter that wraps or reloads early shows up as a wrong high count, and the A=0 and A=N−1 cycles are where such a fault is most exposed. Loads are issued mid-cycle, at boundaries and with illegal pairs. A design that applies a pair immediately, or overwrites the latch on an illegal write, produces a cycle whose counts disagree with the queued expectation. Idle gaps between enables catch a counter that advances on clock instead of on enable.

// File: rtl/divPkg.sv
package divPkg;
  // Strobes from control to datapath; at most one is set in a clock.
  typedef struct packed {
    logic step;    // take one prescaler pulse inside the cycle
    logic reload;  // terminal pulse: load the latched pair
  } divStrb_t;
endpackage

// File: rtl/pulseSwallowCtrl.sv
module pulseSwallowCtrl
  import divPkg::*;
#(
  parameter int N_W   = 11,
  parameter int A_W   = 7,
  parameter int N_MIN = 3,
  parameter int RST_N = 16,
  parameter int RST_A = 0
) (
  input  logic           clk,
  input  logic           rstN,
  input  logic           preEn,
  input  logic           cfgLoad,
  input  logic [N_W-1:0] cfgN,
  input  logic [A_W-1:0] cfgA,
  input  logic           nLast,
  output divStrb_t       strb,
  output logic [N_W-1:0] pendN,
  output logic [A_W-1:0] pendA,
  output logic           cfgErr,
  output logic           divPulse
);
  localparam int PAD_W = N_W - A_W;

  logic [N_W-1:0] cfgAWide;
  logic           cfgLegal;

  assign cfgAWide = {{PAD_W{1'b0}}, cfgA};
  assign cfgLegal = (cfgN >= N_W'(N_MIN)) && (cfgAWide < cfgN);

  always_comb begin
    strb.step   = preEn & ~nLast;
    strb.reload = preEn &  nLast;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pendN    <= N_W'(RST_N);
      pendA    <= A_W'(RST_A);
      cfgErr   <= 1'b0;
      divPulse <= 1'b0;
    end else begin
      divPulse <= strb.reload;
      if (cfgLoad) begin
        if (cfgLegal) begin
          pendN  <= cfgN;
          pendA  <= cfgA;
          cfgErr <= 1'b0;
        end else begin
          cfgErr <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/pulseSwallowPath.sv
module pulseSwallowPath
  import divPkg::*;
#(
  parameter int N_W   = 11,
  parameter int A_W   = 7,
  parameter int RST_N = 16,
  parameter int RST_A = 0
) (
  input  logic           clk,
  input  logic           rstN,
  input  divStrb_t       strb,
  input  logic [N_W-1:0] pendN,
  input  logic [A_W-1:0] pendA,
  output logic           nLast,
  output logic           modCtl
);
  logic [N_W-1:0] nCnt;
  logic [A_W-1:0] aCnt;
  logic           aZero;

  assign aZero  = (aCnt == '0);
  assign nLast  = (nCnt == N_W'(1));
  assign modCtl = ~aZero;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      nCnt <= N_W'(RST_N);
      aCnt <= A_W'(RST_A);
    end else if (strb.reload) begin
      nCnt <= pendN;
      aCnt <= pendA;
    end else if (strb.step) begin
      nCnt <= nCnt - N_W'(1);
      if (!aZero) aCnt <= aCnt - A_W'(1);
    end
  end
endmodule

// File: rtl/pulseSwallowDiv.sv
module pulseSwallowDiv
  import divPkg::*;
#(
  parameter int N_W   = 11,
  parameter int A_W   = 7,
  parameter int N_MIN = 3,
  parameter int RST_N = 16,
  parameter int RST_A = 0
) (
  input  logic           clk,
  input  logic           rstN,
  input  logic           preEn,
  input  logic           cfgLoad,
  input  logic [N_W-1:0] cfgN,
  input  logic [A_W-1:0] cfgA,
  output logic           modCtl,
  output logic           divPulse,
  output logic           cfgErr
);
  divStrb_t       strb;
  logic [N_W-1:0] pendN;
  logic [A_W-1:0] pendA;
  logic           nLast;

  pulseSwallowCtrl #(
    .N_W(N_W), .A_W(A_W), .N_MIN(N_MIN), .RST_N(RST_N), .RST_A(RST_A)
  ) uCtrl (
    .clk(clk), .rstN(rstN), .preEn(preEn), .cfgLoad(cfgLoad),
    .cfgN(cfgN), .cfgA(cfgA), .nLast(nLast), .strb(strb),
    .pendN(pendN), .pendA(pendA), .cfgErr(cfgErr), .divPulse(divPulse)
  );

  pulseSwallowPath #(
    .N_W(N_W), .A_W(A_W), .RST_N(RST_N), .RST_A(RST_A)
  ) uPath (
    .clk(clk), .rstN(rstN), .strb(strb), .pendN(pendN), .pendA(pendA),
    .nLast(nLast), .modCtl(modCtl)
  );
endmodule

// File: rtl/pulseSwallowDivChk.sv
module pulseSwallowDivChk #(
  parameter int N_W   = 11,
  parameter int A_W   = 7,
  parameter int N_MIN = 3
) (
  input logic           clk,
  input logic           rstN,
  input logic           preEn,
  input logic           cfgLoad,
  input logic [N_W-1:0] cfgN,
  input logic [A_W-1:0] cfgA,
  input logic           modCtl,
  input logic           divPulse,
  input logic           cfgErr
);
  // R2: output pulse lasts one clock
  a_r2_pulse_one_wide: assert property (@(posedge clk) disable iff (!rstN)
    divPulse |=> !divPulse);
  // R2: output pulse only follows a taken prescaler pulse
  a_r2_pulse_after_enable: assert property (@(posedge clk) disable iff (!rstN)
    divPulse |-> $past(preEn));
  // R7: idle clock leaves the modulus line alone
  a_r7_idle_holds_mod: assert property (@(posedge clk) disable iff (!rstN)
    !preEn |=> $stable(modCtl));
  // R7: idle clock produces no output pulse
  a_r7_idle_no_pulse: assert property (@(posedge clk) disable iff (!rstN)
    !preEn |=> !divPulse);
  // R3: modulus goes to P+1 only as a new cycle begins
  a_r3_mod_rise_at_boundary: assert property (@(posedge clk) disable iff (!rstN)
    $rose(modCtl) |-> divPulse);
  // R6: error flag moves only after a load
  a_r6_err_moves_on_load: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(cfgErr) |-> $past(cfgLoad));
  // R6: too-small main count is flagged
  a_r6_small_n_flagged: assert property (@(posedge clk) disable iff (!rstN)
    (cfgLoad && (cfgN < N_W'(N_MIN))) |=> cfgErr);
  // R6: swallow count not below main count is flagged
  a_r6_big_a_flagged: assert property (@(posedge clk) disable iff (!rstN)
    (cfgLoad && ({{(N_W-A_W){1'b0}}, cfgA} >= cfgN)) |=> cfgErr);
endmodule

bind pulseSwallowDiv pulseSwallowDivChk #(
  .N_W(N_W), .A_W(A_W), .N_MIN(N_MIN)
) uChk (
  .clk(clk), .rstN(rstN), .preEn(preEn), .cfgLoad(cfgLoad), .cfgN(cfgN),
  .cfgA(cfgA), .modCtl(modCtl), .divPulse(divPulse), .cfgErr(cfgErr)
);

// File: tb/sim_pulseSwallowDiv.sv
`timescale 1ns/1ps
module sim_pulseSwallowDiv;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        preEn = 1'b0;
  logic        cfgLoad = 1'b0;
  logic [10:0] cfgN = '0;
  logic [6:0]  cfgA = '0;
  logic        modCtl, divPulse, cfgErr;

  typedef struct { int n; int a; } item_t;
  item_t expQ[$];

  int checks = 0;
  int fails  = 0;
  int enCnt  = 0;
  int modCnt = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;  // 125 MHz

  pulseSwallowDiv u0 (
    .clk(clk), .rstN(rstN), .preEn(preEn), .cfgLoad(cfgLoad), .cfgN(cfgN),
    .cfgA(cfgA), .modCtl(modCtl), .divPulse(divPulse), .cfgErr(cfgErr)
  );

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic expectCycles(int n, int a, int k);
    for (int i = 0; i < k; i++) begin
      item_t it;
      it.n = n;
      it.a = a;
      expQ.push_back(it);
    end
  endtask

  // Drives count enables; every third one is followed by gap idle clocks.
  task automatic driveEnables(int count, int gap);
    for (int i = 0; i < count; i++) begin
      @(posedge clk); #2;
      preEn = 1'b1;
      if (gap > 0 && (i % 3) == 1) begin
        @(posedge clk); #2;
        preEn = 1'b0;
        repeat (gap) @(posedge clk);
      end
    end
    @(posedge clk); #2;
    preEn = 1'b0;
  endtask

  task automatic loadCfg(int n, int a);
    @(posedge clk); #2;
    cfgLoad = 1'b1;
    cfgN = 11'(n);
    cfgA = 7'(a);
    @(posedge clk); #2;
    cfgLoad = 1'b0;
  endtask

  task automatic finishRun();
    finished = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  // Monitor: compares each completed division cycle against the queue.
  always @(negedge clk) begin
    if (rstN && !finished) begin
      if (divPulse) begin
        if (expQ.size() == 0) begin
          check("R2 unexpected divPulse", 1, 0);
        end else begin
          item_t it;
          it = expQ.pop_front();
          check("R2 enables per cycle", enCnt, it.n);
          if (it.a == 0) check("R4 modCtl high count", modCnt, 0);
          else           check("R3 modCtl high count", modCnt, it.a);
        end
        enCnt  = 0;
        modCnt = 0;
      end
      if (preEn) begin
        enCnt++;
        if (modCtl) modCnt++;
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    check("watchdog expired", 1, 0);
    finishRun();
  end

  initial begin
    repeat (3) @(posedge clk);
    #2;
    check("R1 modCtl at reset", int'(modCtl), 0);
    check("R1 divPulse at reset", int'(divPulse), 0);
    check("R1 cfgErr at reset", int'(cfgErr), 0);
    rstN = 1'b1;

    // R1/R4: default pair 16/0
    expectCycles(16, 0, 1);
    driveEnables(16, 0);

    // R5: boundary load applies after one more old cycle
    loadCfg(100, 7);
    check("R6 cfgErr after legal load", int'(cfgErr), 0);
    expectCycles(16, 0, 1);
    driveEnables(16, 2);
    expectCycles(100, 7, 2);
    driveEnables(200, 1);

    // R5: mid-cycle load leaves the running cycle alone
    expectCycles(100, 7, 1);
    driveEnables(40, 0);
    loadCfg(20, 19);
    driveEnables(60, 3);
    expectCycles(20, 19, 1);
    driveEnables(5, 0);
    // R7: idle clocks mid-swallow change nothing
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      check("R7 modCtl held while idle", int'(modCtl), 1);
      check("R7 no divPulse while idle", int'(divPulse), 0);
    end
    driveEnables(15, 0);

    // R6: illegal pairs flag and keep 20/19
    loadCfg(2, 0);
    check("R6 cfgErr for N<3", int'(cfgErr), 1);
    loadCfg(10, 10);
    check("R6 cfgErr for A>=N", int'(cfgErr), 1);
    expectCycles(20, 19, 2);
    driveEnables(40, 1);

    // R8: smallest legal pair
    loadCfg(3, 2);
    check("R8 cfgErr for 3/2", int'(cfgErr), 0);
    expectCycles(20, 19, 1);
    driveEnables(20, 0);
    expectCycles(3, 2, 3);
    driveEnables(9, 2);

    // R8: largest legal pair
    loadCfg(2047, 127);
    check("R8 cfgErr for 2047/127", int'(cfgErr), 0);
    expectCycles(3, 2, 1);
    driveEnables(3, 0);
    expectCycles(2047, 127, 1);
    driveEnables(2047, 0);

    // R4: back to no swallow
    loadCfg(5, 0);
    expectCycles(2047, 127, 1);
    driveEnables(2047, 0);
    expectCycles(5, 0, 2);
    driveEnables(10, 1);

    repeat (4) @(posedge clk);
    check("R2 all expected cycles seen", expQ.size(), 0);
    finishRun();
  end
endmodule